// File: doc/BRIEF.md
# Write-Back Data Cache with Early Restart

This block is a direct-mapped, write-back data cache that sits between a processor load/store port and a synchronous memory bus of half the width. Loads and stores that hit finish in the cycle they are presented. On a miss, the controller first writes back the old line if it holds modified data. It then fetches the new line from the bus in ascending beat order. The processor stall ends as soon as the requested word is fully stored, and the rest of the line keeps filling in the background.

Each stored word carries a parity bit. A mismatch found on a load is reported to the processor and is not corrected. Each line also holds a small field of coherency flags next to its valid and dirty bits. The flags are captured when the line is allocated and returned on every access. The number of lines, words per line, address width and data widths are all parameters.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, `cpu_ready`, `bus_req` and `bus_wvalid` are low, and the first access to any address is a miss.
- R2: A load or store whose line is resident completes with `cpu_ready` high in the same cycle the request is presented. A load returns the stored word on `cpu_rdata`.
- R3: Each word has even parity. On a fill, the stored parity is the XOR of the `bus_rpar` bits of the word's beats, and memory drives `bus_rpar` equal to the XOR of the beat's bits. A store recomputes parity from its data. A load whose data disagrees with its stored parity raises `cpu_perr` together with `cpu_ready`; `cpu_perr` is otherwise low.
- R4: A store hit updates only the cache and marks the line dirty. It causes no bus request, and memory receives the new data only when the line is evicted.
- R5: A miss that evicts a dirty line writes back all of that line's beats before the fill request is raised. A miss that evicts a clean or invalid line writes nothing back.
- R6: `bus_req`, `bus_we` and `bus_addr` are held until `bus_gnt` is seen. A write beat on `bus_wdata` is held with `bus_wvalid` until `bus_wready`. A read beat is taken in each cycle that `bus_rvalid` is high.
- R7: `bus_addr` is the word address of word 0 of the line. Beats follow in ascending order: beat 2w carries bits 31:0 of word w, and beat 2w+1 carries bits 63:32.
- R8: During a fill, a waiting request for word w is completed one cycle after the bus accepts beat 2w+1. This happens even while later beats of the line are still arriving.
- R9: While a line is filling, accesses to words of that line that have already landed are served. Accesses to words not yet landed stall until their last beat is accepted.
- R10: The value on `line_state_in` when a fill is granted is stored in the line. It is shown on `line_state` with every completed access to that line.
- R11: Addresses with the same index and different tags share one line, so an access to one evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_perr | output | 1 | Parity mismatch on the completing load |
| line_state | output | FLAG_W | Coherency flags of the accessed line |
| line_state_in | input | FLAG_W | Flags written into a line at fill grant |
| bus_req | output | 1 | Burst request |
| bus_we | output | 1 | Burst direction, 1 = write-back |
| bus_addr | output | ADDR_W | Word address of the line's first word |
| bus_gnt | input | 1 | Burst request accepted |
| bus_wvalid | output | 1 | Write beat valid |
| bus_wdata | output | BUS_W | Write beat data |
| bus_wready | input | 1 | Write beat accepted |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | BUS_W | Read beat data |
| bus_rpar | input | 1 | Parity of the read beat |

## Verification
The bench builds the block with 10 address bits, 4 lines of 4 words, 64-bit words and a 32-bit bus. With only 4 lines, two addresses are enough to force dirty and clean evictions, and a 4-word line keeps the number of beats small. That makes the cycle at which each word lands easy to predict. Requests to a word that has landed and to one that has not can both be issued inside one fill. Grant delays and a parity bit flipped on a single beat exercise the handshake hold rule and the error report.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB_REQ,
      ST_WB_DATA,
      ST_FILL_REQ,
      ST_FILL
   } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
`timescale 1ns/1ps
module dcache_tag_store #(
   parameter int LINES  = 64,
   parameter int TAG_W  = 8,
   parameter int FLAG_W = 2,
   parameter int IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [FLAG_W-1:0] rd_flags,
   input  logic              alloc_en,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [FLAG_W-1:0] alloc_flags,
   input  logic              mark_en,
   input  logic [IDX_W-1:0]  mark_idx
);
   logic [LINES-1:0]  valid_vec;
   logic [LINES-1:0]  dirty_vec;
   logic [TAG_W-1:0]  tag_arr  [LINES];
   logic [FLAG_W-1:0] flag_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic              v_q;
      logic              d_q;
      logic [TAG_W-1:0]  t_q;
      logic [FLAG_W-1:0] f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
            f_q <= '0;
         end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            t_q <= alloc_tag;
            f_q <= alloc_flags;
         end else if (mark_en && mark_idx == IDX_W'(i)) begin
            d_q <= 1'b1;
         end
      end
      assign valid_vec[i] = v_q;
      assign dirty_vec[i] = d_q;
      assign tag_arr[i]   = t_q;
      assign flag_arr[i]  = f_q;
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_dirty = dirty_vec[rd_idx];
   assign rd_tag   = tag_arr[rd_idx];
   assign rd_flags = flag_arr[rd_idx];
endmodule

// File: rtl/dcache_data_store.sv
`timescale 1ns/1ps
module dcache_data_store #(
   parameter int LINES  = 64,
   parameter int WPL    = 4,
   parameter int DATA_W = 64,
   parameter int BUS_W  = 32,
   parameter int SLOT_W = $clog2(LINES * WPL),
   parameter int HALF_W = 1
) (
   input  logic              clk,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_par,
   input  logic [SLOT_W-1:0] vr_slot,
   output logic [DATA_W-1:0] vr_data,
   input  logic              cw_en,
   input  logic [SLOT_W-1:0] cw_slot,
   input  logic [DATA_W-1:0] cw_data,
   input  logic              bw_en,
   input  logic [SLOT_W-1:0] bw_slot,
   input  logic [HALF_W-1:0] bw_half,
   input  logic [BUS_W-1:0]  bw_data,
   input  logic              bw_par
);
   localparam int SLOTS = LINES * WPL;

   logic [DATA_W-1:0] word_q [SLOTS];
   logic              par_q  [SLOTS];

   always_ff @(posedge clk) begin
      if (cw_en) begin
         word_q[cw_slot] <= cw_data;
         par_q[cw_slot]  <= ^cw_data;
      end
      if (bw_en) begin
         word_q[bw_slot][int'(bw_half)*BUS_W +: BUS_W] <= bw_data;
         par_q[bw_slot] <= (bw_half == '0) ? bw_par : (par_q[bw_slot] ^ bw_par);
      end
   end

   assign rd_data = word_q[rd_slot];
   assign rd_par  = par_q[rd_slot];
   assign vr_data = word_q[vr_slot];
endmodule

// File: rtl/dcache_beat_seq.sv
`timescale 1ns/1ps
module dcache_beat_seq #(
   parameter int BEATS  = 8,
   parameter int BPW    = 2,
   parameter int WORD_W = 2,
   parameter int HALF_W = 1,
   parameter int CNT_W  = $clog2(BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic              last,
   output logic [WORD_W-1:0] word_idx,
   output logic [HALF_W-1:0] half_idx,
   output logic [WORD_W:0]   words_done
);
   logic [CNT_W-1:0] cnt_q;

   assign last = step && (cnt_q == CNT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (step)  cnt_q <= last ? '0 : cnt_q + 1'b1;
   end

   if (BPW == 1) begin : g_one_beat
      assign word_idx   = cnt_q[WORD_W-1:0];
      assign half_idx   = '0;
      assign words_done = cnt_q[WORD_W:0];
   end else begin : g_multi_beat
      assign word_idx   = cnt_q[HALF_W +: WORD_W];
      assign half_idx   = cnt_q[HALF_W-1:0];
      assign words_done = cnt_q[CNT_W-1:HALF_W];
   end
endmodule

// File: rtl/dcache_wb.sv
`timescale 1ns/1ps
module dcache_wb
   import dcache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LINES  = 64,
   parameter int WPL    = 4,
   parameter int DATA_W = 64,
   parameter int BUS_W  = 32,
   parameter int FLAG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_perr,
   output logic [FLAG_W-1:0] line_state,
   input  logic [FLAG_W-1:0] line_state_in,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   output logic              bus_wvalid,
   output logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_wready,
   input  logic              bus_rvalid,
   input  logic [BUS_W-1:0]  bus_rdata,
   input  logic              bus_rpar
);
   localparam int IDX_W  = $clog2(LINES);
   localparam int WORD_W = $clog2(WPL);
   localparam int TAG_W  = ADDR_W - IDX_W - WORD_W;
   localparam int BPW    = DATA_W / BUS_W;
   localparam int HALF_W = (BPW > 1) ? $clog2(BPW) : 1;
   localparam int BEATS  = WPL * BPW;
   localparam int SLOT_W = IDX_W + WORD_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (WPL < 2 || (1 << WORD_W) != WPL) begin : g_bad_wpl
      $error("WPL must be a power of two of at least 2");
   end
   if (BUS_W > DATA_W || BPW * BUS_W != DATA_W || (BPW > 1 && (1 << HALF_W) != BPW)) begin : g_bad_bus
      $error("DATA_W must be a power-of-two multiple of BUS_W");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for LINES and WPL");
   end

   dc_state_e         st_q, st_d;
   logic [IDX_W-1:0]  miss_idx_q;
   logic [TAG_W-1:0]  miss_tag_q;
   logic [TAG_W-1:0]  vic_tag_q;

   logic [IDX_W-1:0]  c_idx;
   logic [TAG_W-1:0]  c_tag;
   logic [WORD_W-1:0] c_word;

   logic              t_valid, t_dirty;
   logic [TAG_W-1:0]  t_tag;
   logic [FLAG_W-1:0] t_flags;

   logic              seq_clear, seq_step, seq_last;
   logic [WORD_W-1:0] seq_word;
   logic [HALF_W-1:0] seq_half;
   logic [WORD_W:0]   words_done;

   logic [DATA_W-1:0] rd_data, vr_data;
   logic              rd_par;
   logic              alloc_en;

   logic              fill_active, tag_hit, word_landed, serve, miss_go;

   assign c_word = cpu_addr[WORD_W-1:0];
   assign c_idx  = cpu_addr[WORD_W +: IDX_W];
   assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

   dcache_tag_store #(
      .LINES(LINES), .TAG_W(TAG_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)
   ) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(c_idx), .rd_valid(t_valid), .rd_dirty(t_dirty),
      .rd_tag(t_tag), .rd_flags(t_flags),
      .alloc_en(alloc_en), .alloc_idx(miss_idx_q), .alloc_tag(miss_tag_q),
      .alloc_flags(line_state_in),
      .mark_en(serve && cpu_we), .mark_idx(c_idx)
   );

   dcache_data_store #(
      .LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .BUS_W(BUS_W),
      .SLOT_W(SLOT_W), .HALF_W(HALF_W)
   ) u_data (
      .clk(clk),
      .rd_slot({c_idx, c_word}), .rd_data(rd_data), .rd_par(rd_par),
      .vr_slot({miss_idx_q, seq_word}), .vr_data(vr_data),
      .cw_en(serve && cpu_we), .cw_slot({c_idx, c_word}), .cw_data(cpu_wdata),
      .bw_en(fill_active && bus_rvalid), .bw_slot({miss_idx_q, seq_word}),
      .bw_half(seq_half), .bw_data(bus_rdata), .bw_par(bus_rpar)
   );

   dcache_beat_seq #(
      .BEATS(BEATS), .BPW(BPW), .WORD_W(WORD_W), .HALF_W(HALF_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .clear(seq_clear), .step(seq_step), .last(seq_last),
      .word_idx(seq_word), .half_idx(seq_half), .words_done(words_done)
   );

   // Hit detection with early restart: in the line being filled, only
   // words whose final beat has been accepted count as present.
   assign fill_active = (st_q == ST_FILL);
   assign tag_hit     = t_valid && (t_tag == c_tag);
   assign word_landed = !(fill_active && c_idx == miss_idx_q)
                        || ({1'b0, c_word} < words_done);
   assign serve       = cpu_req && tag_hit && word_landed
                        && (st_q == ST_IDLE || fill_active);
   assign miss_go     = cpu_req && !tag_hit && (st_q == ST_IDLE);

   always_comb begin
      st_d       = st_q;
      seq_clear  = 1'b0;
      seq_step   = 1'b0;
      alloc_en   = 1'b0;
      bus_req    = 1'b0;
      bus_we     = 1'b0;
      bus_addr   = '0;
      bus_wvalid = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (miss_go) st_d = (t_valid && t_dirty) ? ST_WB_REQ : ST_FILL_REQ;
         end
         ST_WB_REQ: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = {vic_tag_q, miss_idx_q, {WORD_W{1'b0}}};
            if (bus_gnt) begin
               seq_clear = 1'b1;
               st_d      = ST_WB_DATA;
            end
         end
         ST_WB_DATA: begin
            bus_wvalid = 1'b1;
            seq_step   = bus_wready;
            if (seq_last) st_d = ST_FILL_REQ;
         end
         ST_FILL_REQ: begin
            bus_req  = 1'b1;
            bus_addr = {miss_tag_q, miss_idx_q, {WORD_W{1'b0}}};
            if (bus_gnt) begin
               alloc_en  = 1'b1;
               seq_clear = 1'b1;
               st_d      = ST_FILL;
            end
         end
         ST_FILL: begin
            seq_step = bus_rvalid;
            if (seq_last) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         miss_idx_q <= '0;
         miss_tag_q <= '0;
         vic_tag_q  <= '0;
      end else begin
         st_q <= st_d;
         if (miss_go) begin
            miss_idx_q <= c_idx;
            miss_tag_q <= c_tag;
            vic_tag_q  <= t_tag;
         end
      end
   end

   assign bus_wdata  = vr_data[int'(seq_half)*BUS_W +: BUS_W];
   assign cpu_ready  = serve;
   assign cpu_rdata  = rd_data;
   assign cpu_perr   = serve && !cpu_we && ((^rd_data) != rd_par);
   assign line_state = t_flags;
endmodule

// File: rtl/dcache_wb_chk.sv
`timescale 1ns/1ps
module dcache_wb_chk #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 6,
   parameter int WORD_W = 2,
   parameter int BUS_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              cpu_perr,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              bus_wvalid,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              bus_wready,
   input logic              fill_active,
   input logic [IDX_W-1:0]  fill_idx,
   input logic [WORD_W:0]   words_done
);
   // R2: completion only answers a pending request
   a_r2_ready_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R3: parity error only reported on a completing load
   a_r3_perr_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_perr |-> (cpu_ready && !cpu_we));

   // R5: write-back beats never overlap a fill
   a_r5_wb_outside_fill: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wvalid |-> !fill_active);

   // R6: request held until grant
   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R6: write beat held until accepted
   a_r6_wbeat_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wvalid && !bus_wready) |=> (bus_wvalid && $stable(bus_wdata)));

   // R9: a served access to the filling line names a landed word
   a_r9_landed_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && fill_active && cpu_addr[WORD_W +: IDX_W] == fill_idx)
      |-> ({1'b0, cpu_addr[WORD_W-1:0]} < words_done));
endmodule

bind dcache_wb dcache_wb_chk #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .BUS_W(BUS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .cpu_perr(cpu_perr),
   .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
   .bus_wvalid(bus_wvalid), .bus_wdata(bus_wdata), .bus_wready(bus_wready),
   .fill_active(fill_active), .fill_idx(miss_idx_q), .words_done(words_done)
);

// File: tb/dcache_wb_bench.sv
`timescale 1ns/1ps
module dcache_wb_bench;
   localparam int AW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [63:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_perr;
   logic [63:0] cpu_rdata;
   logic [1:0]  line_state;
   logic [1:0]  line_state_in = 2'b10;
   logic        bus_req, bus_we, bus_wvalid;
   logic [AW-1:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_gnt = 1'b0, bus_wready = 1'b0, bus_rvalid = 1'b0, bus_rpar = 1'b0;
   logic [31:0] bus_rdata = '0;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dcache_wb #(.ADDR_W(AW), .LINES(4), .WPL(4), .DATA_W(64), .BUS_W(32), .FLAG_W(2))
   u_dcache_wb (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_perr(cpu_perr),
      .line_state(line_state), .line_state_in(line_state_in),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
      .bus_wvalid(bus_wvalid), .bus_wdata(bus_wdata), .bus_wready(bus_wready),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rpar(bus_rpar)
   );

   // memory model
   logic [63:0] mem [1024];
   int mode = 0;
   logic [AW-1:0] rbase = '0;
   int rbeat = 0, req_cyc = 0, gnt_delay = 0, corrupt_beat = -1;
   int n_wb_beats = 0, n_rd_req = 0, n_wr_req = 0, wb_at_rd = 0;
   logic [AW-1:0] last_rd_addr = '0, last_wr_addr = '0;

   function automatic logic [63:0] pat(int i);
      logic [31:0] u = i;
      return {32'hC0DE0000 | u, ~u ^ 32'h0F0F0F0F};
   endfunction

   function automatic logic [AW-1:0] mk(int tag, int idx, int w);
      return AW'((tag << 4) | (idx << 2) | w);
   endfunction

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = pat(i);
      forever begin
         @(posedge clk);
         if (mode == 0 && bus_req && bus_gnt) begin
            rbase = bus_addr;
            rbeat = 0;
            if (bus_we) begin
               mode = 1; n_wr_req++; last_wr_addr = bus_addr;
            end else begin
               mode = 2; n_rd_req++; wb_at_rd = n_wb_beats; last_rd_addr = bus_addr;
            end
         end else if (mode == 1 && bus_wvalid && bus_wready) begin
            if (rbeat % 2 == 0) mem[int'(rbase) + rbeat/2][31:0]  = bus_wdata;
            else                mem[int'(rbase) + rbeat/2][63:32] = bus_wdata;
            rbeat++; n_wb_beats++;
            if (rbeat == 8) mode = 0;
         end else if (mode == 2 && bus_rvalid) begin
            rbeat++;
            if (rbeat == 8) begin mode = 0; corrupt_beat = -1; end
         end
         @(negedge clk);
         if (mode == 0 && bus_req) req_cyc++; else req_cyc = 0;
         bus_gnt    = (mode == 0) && bus_req && (req_cyc > gnt_delay);
         bus_wready = (mode == 1);
         bus_rvalid = (mode == 2);
         if (mode == 2) begin
            bus_rdata = (rbeat % 2 == 0) ? mem[int'(rbase) + rbeat/2][31:0]
                                         : mem[int'(rbase) + rbeat/2][63:32];
            bus_rpar  = (^bus_rdata) ^ (rbeat == corrupt_beat);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [AW-1:0] a, input logic [63:0] wd,
                      output logic [63:0] rd, output logic pe, output logic [1:0] ls,
                      output int cyc, output logic rv);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cyc = 0;
      #1;
      while (!cpu_ready && cyc < 500) begin
         @(negedge clk); cyc++; #1;
      end
      rd = cpu_rdata; pe = cpu_perr; ls = line_state; rv = bus_rvalid;
      @(posedge clk); @(negedge clk);
      cpu_req = 1'b0;
   endtask

   logic [63:0] rd;
   logic pe, rv;
   logic [1:0] ls;
   int cyc;

   task automatic t_reset();
      chk(cpu_ready == 1'b0, "R1", "ready after reset", cpu_ready, 0);
      chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
      chk(bus_wvalid == 1'b0, "R1", "wvalid after reset", bus_wvalid, 0);
   endtask

   task automatic t_restart();
      logic [AW-1:0] a0 = mk(1, 1, 0);
      gnt_delay = 0; line_state_in = 2'b10;
      acc(0, a0, 0, rd, pe, ls, cyc, rv);
      chk(cyc == 4, "R8", "word0 restart cycles", cyc, 4);
      chk(rv == 1'b1, "R8", "fill still running at restart", rv, 1);
      chk(rd == pat(int'(a0)), "R7", "word0 data", rd, pat(int'(a0)));
      chk(ls == 2'b10, "R10", "flags captured", ls, 2'b10);
      chk(last_rd_addr == mk(1, 1, 0), "R7", "burst address", last_rd_addr, mk(1, 1, 0));
      chk(cyc > 0, "R1", "first access misses", cyc, 1);
      acc(0, mk(1, 1, 1), 0, rd, pe, ls, cyc, rv);
      chk(cyc == 1, "R9", "word1 waits for its beat", cyc, 1);
      chk(rd == pat(int'(mk(1, 1, 1))), "R7", "word1 data", rd, pat(int'(mk(1, 1, 1))));
      acc(0, a0, 0, rd, pe, ls, cyc, rv);
      chk(cyc == 0 && rv == 1'b1, "R9", "landed word served during fill", cyc, 0);
      acc(0, mk(1, 1, 3), 0, rd, pe, ls, cyc, rv);
      chk(cyc == 2, "R9", "undelivered word3 stalls", cyc, 2);
      chk(rd == pat(int'(mk(1, 1, 3))), "R7", "word3 data high/low order", rd, pat(int'(mk(1, 1, 3))));
   endtask

   task automatic t_store_hit();
      int rq0 = n_rd_req + n_wr_req;
      logic [AW-1:0] a = mk(1, 1, 2);
      acc(1, a, 64'hDEAD_BEEF_0123_4567, rd, pe, ls, cyc, rv);
      chk(cyc == 0, "R2", "store hit same cycle", cyc, 0);
      repeat (3) @(negedge clk);
      chk(n_rd_req + n_wr_req == rq0, "R4", "no bus traffic on store", n_rd_req + n_wr_req, rq0);
      chk(mem[int'(a)] == pat(int'(a)), "R4", "memory untouched", mem[int'(a)], pat(int'(a)));
      acc(0, a, 0, rd, pe, ls, cyc, rv);
      chk(cyc == 0 && rd == 64'hDEAD_BEEF_0123_4567, "R2", "load hit data", rd, 64'hDEAD_BEEF_0123_4567);
      chk(pe == 1'b0, "R3", "store parity recomputed", pe, 0);
      line_state_in = 2'b01;
      acc(0, a, 0, rd, pe, ls, cyc, rv);
      chk(ls == 2'b10, "R10", "flags kept on hit", ls, 2'b10);
   endtask

   task automatic t_evict();
      int wb0 = n_wb_beats;
      logic [AW-1:0] b = mk(2, 1, 1);
      gnt_delay = 2;
      acc(0, b, 0, rd, pe, ls, cyc, rv);
      chk(n_wb_beats - wb0 == 8, "R5", "full write-back beats", n_wb_beats - wb0, 8);
      chk(wb_at_rd == wb0 + 8, "R5", "write-back before fill request", wb_at_rd, wb0 + 8);
      chk(last_wr_addr == mk(1, 1, 0), "R7", "write-back address", last_wr_addr, mk(1, 1, 0));
      chk(mem[int'(mk(1, 1, 2))] == 64'hDEAD_BEEF_0123_4567, "R4", "dirty data reaches memory",
          mem[int'(mk(1, 1, 2))], 64'hDEAD_BEEF_0123_4567);
      chk(rd == pat(int'(b)), "R6", "data after delayed grant", rd, pat(int'(b)));
      chk(ls == 2'b01, "R10", "new flags on new line", ls, 2'b01);
      repeat (12) @(negedge clk);
      wb0 = n_wb_beats;
      acc(0, mk(1, 1, 0), 0, rd, pe, ls, cyc, rv);
      chk(cyc > 0, "R11", "conflicting tag was evicted", cyc, 1);
      chk(n_wb_beats == wb0, "R5", "clean victim not written back", n_wb_beats, wb0);
      chk(rd == pat(int'(mk(1, 1, 0))), "R11", "reload data", rd, pat(int'(mk(1, 1, 0))));
      gnt_delay = 0;
      repeat (12) @(negedge clk);
   endtask

   task automatic t_parity();
      corrupt_beat = 2;
      acc(0, mk(3, 2, 0), 0, rd, pe, ls, cyc, rv);
      chk(pe == 1'b0, "R3", "good word no error", pe, 0);
      acc(0, mk(3, 2, 1), 0, rd, pe, ls, cyc, rv);
      chk(pe == 1'b1, "R3", "bad beat parity flagged", pe, 1);
      chk(rd == pat(int'(mk(3, 2, 1))), "R3", "data not altered", rd, pat(int'(mk(3, 2, 1))));
      acc(0, mk(3, 2, 2), 0, rd, pe, ls, cyc, rv);
      chk(pe == 1'b0, "R3", "next word no error", pe, 0);
      acc(1, mk(3, 2, 1), 64'h0000_1111_2222_3333, rd, pe, ls, cyc, rv);
      chk(pe == 1'b0, "R3", "no error on store", pe, 0);
      acc(0, mk(3, 2, 1), 0, rd, pe, ls, cyc, rv);
      chk(pe == 1'b0 && rd == 64'h0000_1111_2222_3333, "R3", "store clears bad parity", pe, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_restart();
            @(negedge clk);
            t_store_hit();
            t_evict();
            t_parity();
         end
         begin
            repeat (200000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule